// File: doc/BRIEF.md
# Stop-Mode Wake Sequencer

This block puts a microcontroller into one of two deep low-power states and brings it back out in order. A one-cycle stop request from the CPU chooses between a plain stop, where the CPU clock and the main oscillator are switched off, and a PLL stop, where the frequency-multiplying PLL is switched off as well. While stopped, the block watches a set of external interrupt sources. Each source has a 3-bit priority level, and a lower value means a more urgent source.

A pending source whose level is below the fully masked value 7 ends the stop. The oscillator and the PLL are switched back on together. A single counter then times the settling period for both of them. The length of that period is chosen by a 2-bit wait-select field, which is captured when the stop begins.

When the period expires, the CPU clock restarts and the block gives a one-cycle resume pulse. In the same cycle it reports whether the CPU takes the pending interrupt or simply continues with the next instruction. A PLL stop requested with a settling wait that is too short is refused, and the refusal is recorded in a sticky error flag.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is running: `osc_en`, `pll_en` and `cpu_clk_en` are 1, and `resume_pulse`, `take_irq` and `cfg_err` are 0.
- R2: A `stop_req` while running, with a valid configuration, drops `cpu_clk_en` and `osc_en` to 0 from the next cycle. `pll_en` also drops to 0 only when `stop_pll` is 1.
- R3: A request with `stop_pll`=1 and `wait_sel` 00 or 01 is refused. The block keeps running with all enables at 1, and `cfg_err` rises and stays 1 until reset.
- R4: Only a pending source whose level is not 7 (binary 111) ends a stop. Pending sources at level 7 leave all enables at 0.
- R5: Once woken, `osc_en` and `pll_en` are 1 and `cpu_clk_en` stays 0 for exactly 2^E cycles. E is WEXP0, WEXP1, WEXP2 or WEXP3 for `wait_sel` 00, 01, 10 or 11, with defaults 10, 13, 15 and 17, so both PLL-stop settings give at least 2^14 cycles.
- R6: `wait_sel` is captured on stop entry. Changing it while stopped or waiting does not alter the wait length.
- R7: In the first cycle after the wait, `cpu_clk_en` returns to 1 and `resume_pulse` is 1 for exactly that one cycle.
- R8: `take_irq` is 1 together with `resume_pulse` exactly when `glob_ie` is 1 and the winning level is numerically below `mask_lvl`. Both are sampled in the last wait cycle. The winning level is the lowest level among the pending sources whose level is not 7. With no such source pending, `take_irq` is 0.
- R9: `stop_req` is ignored while the block is stopped or waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to enter a stop state |
| stop_pll | input | 1 | With `stop_req`: 1 selects PLL stop, 0 selects plain stop |
| wait_sel | input | 2 | Settling-wait select, captured on entry |
| irq_req | input | N_SRC | Pending flag per external source |
| irq_lvl | input | N_SRC*3 | Priority level per source, source i in bits [3i+2:3i] |
| glob_ie | input | 1 | Global interrupt enable |
| mask_lvl | input | 3 | Current mask level |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| resume_pulse | output | 1 | One-cycle pulse when the CPU clock restarts |
| take_irq | output | 1 | CPU takes the interrupt (valid with `resume_pulse`) |
| cfg_err | output | 1 | Sticky refused-PLL-stop flag |

## Verification
The bench builds the block with three sources and wait exponents 2, 3, 4 and 5. This makes each settling wait only a few cycles long, so the exact wait length can be counted for every `wait_sel` value in both stop modes. It also makes it affordable to run the full sweep of winning level 0 to 6, mask level 0 to 7 and both values of the global enable. In each stop, the bench changes `wait_sel`, holds level-7 sources pending and pulses `stop_req` while the block is stopped or waiting. A multi-source case checks that the lowest pending level decides acceptance.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2
    } swc_state_e;

    typedef struct packed {
        swc_state_e st;
        logic       pll;
        logic [1:0] ws;
        logic       resume;
        logic       take;
        logic       err;
    } swc_regs_t;

endpackage

// File: rtl/swc_prio.sv
module swc_prio #(
    parameter int N_SRC = 4,
    parameter int LVL_W = 3
) (
    input  logic [N_SRC-1:0]       req_i,
    input  logic [N_SRC*LVL_W-1:0] lvl_i,
    output logic                   wake_o,
    output logic [LVL_W-1:0]       win_lvl_o
);
    localparam logic [LVL_W-1:0] LVL_MASKED = '1;

    always_comb begin
        wake_o    = 1'b0;
        win_lvl_o = LVL_MASKED;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && (lvl_i[i*LVL_W +: LVL_W] != LVL_MASKED)) begin
                if (!wake_o || (lvl_i[i*LVL_W +: LVL_W] < win_lvl_o)) begin
                    win_lvl_o = lvl_i[i*LVL_W +: LVL_W];
                end
                wake_o = 1'b1;
            end
        end
    end

    always_comb begin
        if (wake_o) begin
            AST_WAKE_NOT_MASKED: assert (win_lvl_o != LVL_MASKED); // R4
        end
    end

endmodule

// File: rtl/swc_wait_cnt.sv
module swc_wait_cnt #(
    parameter int WEXP0 = 10,
    parameter int WEXP1 = 13,
    parameter int WEXP2 = 15,
    parameter int WEXP3 = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       done_o
);
    localparam int EMAX01 = (WEXP0 > WEXP1) ? WEXP0 : WEXP1;
    localparam int EMAX23 = (WEXP2 > WEXP3) ? WEXP2 : WEXP3;
    localparam int EMAX   = (EMAX01 > EMAX23) ? EMAX01 : EMAX23;
    localparam int CNT_W  = EMAX + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        case (sel_i)
            2'b00:   limit = CNT_W'(1) << WEXP0;
            2'b01:   limit = CNT_W'(1) << WEXP1;
            2'b10:   limit = CNT_W'(1) << WEXP2;
            default: limit = CNT_W'(1) << WEXP3;
        endcase
    end

    assign done_o = run_i && (cnt_q == limit - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit)); // R5

    AST_CNT_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int WEXP0 = 10,
    parameter int WEXP1 = 13,
    parameter int WEXP2 = 15,
    parameter int WEXP3 = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic               stop_pll,
    input  logic [1:0]         wait_sel,
    input  logic [N_SRC-1:0]   irq_req,
    input  logic [N_SRC*3-1:0] irq_lvl,
    input  logic               glob_ie,
    input  logic [2:0]         mask_lvl,
    output logic               osc_en,
    output logic               pll_en,
    output logic               cpu_clk_en,
    output logic               resume_pulse,
    output logic               take_irq,
    output logic               cfg_err
);
    localparam int LVL_W = 3;

    swc_regs_t        r_d, r_q;
    logic             wake;
    logic [LVL_W-1:0] win_lvl;
    logic             wait_done;

    swc_prio #(.N_SRC(N_SRC), .LVL_W(LVL_W)) i_prio (
        .req_i     (irq_req),
        .lvl_i     (irq_lvl),
        .wake_o    (wake),
        .win_lvl_o (win_lvl)
    );

    swc_wait_cnt #(.WEXP0(WEXP0), .WEXP1(WEXP1), .WEXP2(WEXP2), .WEXP3(WEXP3)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (r_q.st == ST_STOP),
        .run_i   (r_q.st == ST_WAIT),
        .sel_i   (r_q.ws),
        .done_o  (wait_done)
    );

    always_comb begin
        r_d        = r_q;
        r_d.resume = 1'b0;
        r_d.take   = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (stop_req) begin
                    if (stop_pll && !wait_sel[1]) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st  = ST_STOP;
                        r_d.pll = stop_pll;
                        r_d.ws  = wait_sel;
                    end
                end
            end
            ST_STOP: begin
                if (wake) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wait_done) begin
                    r_d.st     = ST_RUN;
                    r_d.pll    = 1'b0;
                    r_d.resume = 1'b1;
                    r_d.take   = glob_ie && wake && (win_lvl < mask_lvl);
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, pll: 1'b0, ws: 2'b00, resume: 1'b0, take: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_clk_en   = (r_q.st == ST_RUN);
    assign osc_en       = (r_q.st != ST_STOP);
    assign pll_en       = !((r_q.st == ST_STOP) && r_q.pll);
    assign resume_pulse = r_q.resume;
    assign take_irq     = r_q.take;
    assign cfg_err      = r_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R3

    AST_PLL_STOP_LONG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_en) |-> r_q.ws[1]); // R3

    AST_WS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_RUN) |=> ((r_q.st == ST_RUN) || $stable(r_q.ws))); // R6

    AST_OSC_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> ($past(osc_en) && $past(pll_en))); // R5

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse); // R7

    AST_TAKE_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (resume_pulse && cpu_clk_en)); // R8

    AST_STOP_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_STOP) && !wake) |=> !osc_en); // R4

endmodule

// File: tb/test_stop_wake_ctrl.sv
`timescale 1ns/1ps
module test_stop_wake_ctrl;
    localparam int NS = 3;
    localparam int E0 = 2, E1 = 3, E2 = 4, E3 = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, stop_pll = 1'b0, glob_ie = 1'b0;
    logic [1:0] wait_sel = 2'b00;
    logic [NS-1:0] irq_req = '0;
    logic [NS*3-1:0] irq_lvl = '1;
    logic [2:0] mask_lvl = 3'd0;
    logic osc_en, pll_en, cpu_clk_en, resume_pulse, take_irq, cfg_err;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    stop_wake_ctrl #(.N_SRC(NS), .WEXP0(E0), .WEXP1(E1), .WEXP2(E2), .WEXP3(E3)) i_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_pll(stop_pll),
        .wait_sel(wait_sel), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .glob_ie(glob_ie), .mask_lvl(mask_lvl), .osc_en(osc_en), .pll_en(pll_en),
        .cpu_clk_en(cpu_clk_en), .resume_pulse(resume_pulse), .take_irq(take_irq),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wait_len(input int ws);
        case (ws)
            0: return 1 << E0;
            1: return 1 << E1;
            2: return 1 << E2;
            default: return 1 << E3;
        endcase
    endfunction

    // enter stop, hold masked sources, wake with given levels, check wait and decision
    task automatic run_cycle(input int ws, input int pll, input logic [NS-1:0] req,
                             input logic [NS*3-1:0] lvl, input int g, input int m,
                             input int exp_take);
        int n;
        @(negedge clk);
        stop_req = 1'b1; stop_pll = pll[0]; wait_sel = ws[1:0];
        @(negedge clk);
        stop_req = 1'b0;
        chk("R2 clk off", cpu_clk_en, 0);
        chk("R2 osc off", osc_en, 0);
        chk("R2 pll", pll_en, pll ? 0 : 1);
        wait_sel = ~ws[1:0];                 // R6: must not matter
        irq_req = '1; irq_lvl = '1;          // R4: all pending at level 7
        stop_req = 1'b1; stop_pll = 1'b0;    // R9: ignored while stopped
        repeat (3) @(negedge clk);
        stop_req = 1'b0;
        chk("R4 masked no wake", {29'd0, osc_en, cpu_clk_en}, 0);
        irq_req = req; irq_lvl = lvl; glob_ie = g[0]; mask_lvl = m[2:0];
        @(negedge clk);
        n = 0;
        while (!cpu_clk_en && n < 200) begin
            if (n == 1) stop_req = 1'b1;     // R9
            if (n == 2) stop_req = 1'b0;
            if (!(osc_en && pll_en)) chk("R5 enables during wait", 0, 1);
            n++;
            @(negedge clk);
        end
        stop_req = 1'b0;
        chk("R5 R6 wait length", n, wait_len(ws));
        chk("R7 resume", resume_pulse, 1);
        chk("R8 take", take_irq, exp_take);
        irq_req = '0;
        @(negedge clk);
        chk("R7 one cycle", resume_pulse, 0);
        chk("R9 still running", cpu_clk_en, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 osc", osc_en, 1);
        chk("R1 pll", pll_en, 1);
        chk("R1 clk", cpu_clk_en, 1);
        chk("R1 flags", {29'd0, resume_pulse, take_irq, cfg_err}, 0);

        // R3: refused PLL stops
        for (int ws = 0; ws < 2; ws++) begin
            @(negedge clk);
            stop_req = 1'b1; stop_pll = 1'b1; wait_sel = ws[1:0];
            @(negedge clk);
            stop_req = 1'b0;
            chk("R3 stays running", {29'd0, osc_en, pll_en, cpu_clk_en}, 7);
            chk("R3 err set", cfg_err, 1);
        end

        // R5 R6: every wait setting in both legal modes
        for (int ws = 0; ws < 4; ws++)
            for (int p = 0; p < 2; p++)
                if (!(p == 1 && ws < 2))
                    run_cycle(ws, p, 3'b001, 9'o773, 1, 7, 1);

        // R8: full sweep of level, mask and enable
        for (int l = 0; l < 7; l++)
            for (int m = 0; m < 8; m++)
                for (int g = 0; g < 2; g++)
                    run_cycle(0, 0, 3'b010, {3'd7, l[2:0], 3'd7}, g, m,
                              (g == 1 && l < m) ? 1 : 0);

        // R8: lowest pending level wins among several sources
        run_cycle(2, 1, 3'b011, {3'd7, 3'd2, 3'd5}, 1, 3, 1);
        run_cycle(3, 0, 3'b101, {3'd4, 3'd0, 3'd6}, 1, 5, 1);
        run_cycle(2, 0, 3'b110, {3'd6, 3'd5, 3'd1}, 1, 5, 0);
        chk("R3 err sticky", cfg_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule